// File: doc/BRIEF.md
# Triplicated Adder Result Checker

This block exercises a group of externally built 4-bit adders and judges every result they return. It presents two operands to the adders: the second is held at the constant one, and the first starts at zero after reset and steps up by one after a programmable number of effective ticks. An effective tick is produced internally from the system clock by a programmable divider. All of the block's state advances only on that tick.

Four 5-bit results come back: three independent raw sums and one sum already voted outside the block. The block forms its own bitwise two-of-three vote of the raw sums and compares all five values against the sum it works out itself. It does this on every effective tick, not only when the operand changes, so a disturbance on an adder whose input is held still gets caught. When any result is wrong, or when a programmable report period runs out, the block fills a single report slot. The slot records the operand, all five values, the expected sum, a mismatch mask, a report kind and a timestamp, and offers them on a valid/ready handshake.

Top module: `tmr_adder_checker`

## Requirements
- R1: `eff_tick` is high on every cycle when `div_cfg` is 0 or 1. Otherwise it is high on exactly one cycle in every `div_cfg` consecutive cycles. Operand, timestamp, report counter and report slot change only on a tick, and the slot also changes on a handshake.
- R2: `op_b` is always binary 0001. `op_a` is 0 after reset. It increments by one, modulo 16, on every `step_cfg`-th tick, and a `step_cfg` of 0 behaves as 1. It never changes in any other way.
- R3: The local vote `rec_loc` is the bitwise two-of-three majority of the three raw sums.
- R4: On every tick, each of the five results is compared with `op_a + op_b` as a 5-bit value with the carry in bit 4. This holds whether or not the operand changed on that tick. Mask bit 0, 1 and 2 flag raw sums a, b and c, bit 3 flags the external vote and bit 4 flags the local vote. A set bit means a mismatch.
- R5: A tick with a non-zero mask raises an error report, and the error report sets `rec_kind` bit 0.
- R6: When `rpt_cfg` is non-zero, a periodic report is raised on every `rpt_cfg`-th tick, and it sets `rec_kind` bit 1. An error and a periodic report on the same tick give one record with both kind bits set. A `rpt_cfg` of 0 disables periodic reports.
- R7: A record carries the operand A of its tick, the three raw sums, the external vote, the local vote, the expected sum, the mask, the kind and the timestamp of that tick.
- R8: The timestamp is 0 after reset and counts effective ticks. A record takes the count as it stood before its own tick.
- R9: While `rec_valid` is high and `rec_ready` is low, the record is held unchanged. A report raised at that time is discarded. A report may refill the slot on the same cycle that the old record is accepted.
- R10: Reset clears `op_a`, the timestamp and `rec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| div_cfg | input | DIV_W | Tick divider N (0 or 1: full rate) |
| step_cfg | input | INTV_W | Ticks per operand step |
| rpt_cfg | input | RPT_W | Ticks per periodic report (0: off) |
| eff_tick | output | 1 | Effective tick enable |
| op_a | output | OPW | Stepping operand |
| op_b | output | OPW | Constant operand (one) |
| sum_a | input | OPW+1 | Raw sum from adder copy a |
| sum_b | input | OPW+1 | Raw sum from adder copy b |
| sum_c | input | OPW+1 | Raw sum from adder copy c |
| sum_voted | input | OPW+1 | Sum voted outside the block |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_valid | output | 1 | Record slot holds a report |
| rec_op_a | output | OPW | Operand A of the reported tick |
| rec_raw_a | output | OPW+1 | Raw sum a captured |
| rec_raw_b | output | OPW+1 | Raw sum b captured |
| rec_raw_c | output | OPW+1 | Raw sum c captured |
| rec_ext | output | OPW+1 | External vote captured |
| rec_loc | output | OPW+1 | Local vote captured |
| rec_exp | output | OPW+1 | Expected sum |
| rec_mask | output | 5 | Mismatch mask |
| rec_kind | output | 2 | Bit 0 error, bit 1 periodic |
| rec_ts | output | TS_W | Tick timestamp |

## Verification
The two functions that can land on the same tick are the error report and the periodic report. The bench provokes this by running at full rate with a short report period while raw sum a carries a fault on every tick, so every third tick is both wrong and due. Each such record must appear once, with both kind bits set and a mask that names only copy a. A reference model in the bench predicts every record, and a count of records with both kind bits confirms that the overlap really happened.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int unsigned NRES   = 5;  // checked results
  localparam int unsigned NRAW   = 3;  // raw adder copies
  localparam int unsigned M_EXT  = 3;  // mask bit: external vote
  localparam int unsigned M_LOC  = 4;  // mask bit: local vote
  localparam int unsigned KIND_W = 2;
  localparam int unsigned K_ERR  = 0;  // kind bit: mismatch seen
  localparam int unsigned K_PER  = 1;  // kind bit: period elapsed
  typedef logic [NRES-1:0]   mask_t;
  typedef logic [KIND_W-1:0] kind_t;
endpackage

// File: rtl/tac_tick_gen.sv
module tac_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (div_cfg <= DIV_W'(1)) || (cnt_q >= div_cfg - DIV_W'(1));
    cnt_d = tick ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: a divided tick is followed by a quiet cycle unless the divider drops to full rate
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_cfg > DIV_W'(1)) |=> (!tick || div_cfg <= DIV_W'(1)));
endmodule

// File: rtl/tac_stim_gen.sv
module tac_stim_gen #(
  parameter int unsigned OPW    = 4,
  parameter int unsigned INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [INTV_W-1:0] step_cfg,
  output logic [OPW-1:0]    op_a,
  output logic [OPW-1:0]    op_b
);
  logic [OPW-1:0]    a_q, a_d;
  logic [INTV_W-1:0] step_q, step_d;
  logic              step_last;

  always_comb begin
    step_last = (step_cfg <= INTV_W'(1)) || (step_q >= step_cfg - INTV_W'(1));
    a_d    = a_q;
    step_d = step_q;
    if (tick) begin
      if (step_last) begin
        a_d    = a_q + OPW'(1);
        step_d = '0;
      end else begin
        step_d = step_q + INTV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      step_q <= '0;
    end else begin
      a_q    <= a_d;
      step_q <= step_d;
    end
  end

  assign op_a = a_q;
  assign op_b = OPW'(1);

  // R2: operand A moves only on a tick
  assert_opa_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(op_a));
  // R2: any change of operand A is a single increment
  assert_opa_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a != $past(op_a)) |-> (op_a == OPW'($past(op_a) + OPW'(1))));
endmodule

// File: rtl/tac_result_check.sv
module tac_result_check
  import tac_pkg::*;
#(
  parameter int unsigned OPW  = 4,
  parameter int unsigned SUMW = OPW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OPW-1:0]            op_a,
  input  logic [OPW-1:0]            op_b,
  input  logic [NRAW-1:0][SUMW-1:0] raw,
  input  logic [SUMW-1:0]           ext,
  output logic [SUMW-1:0]           expect_sum,
  output logic [SUMW-1:0]           vote,
  output mask_t                     mask
);
  logic [NRES-1:0][SUMW-1:0] res;

  assign expect_sum = SUMW'(op_a) + SUMW'(op_b);

  generate
    for (genvar b = 0; b < SUMW; b++) begin : g_vote
      assign vote[b] = (raw[0][b] & raw[1][b]) |
                       (raw[0][b] & raw[2][b]) |
                       (raw[1][b] & raw[2][b]);
    end
    for (genvar r = 0; r < NRAW; r++) begin : g_raw
      assign res[r] = raw[r];
    end
  endgenerate

  assign res[M_EXT] = ext;
  assign res[M_LOC] = vote;

  generate
    for (genvar m = 0; m < NRES; m++) begin : g_cmp
      assign mask[m] = (res[m] != expect_sum);
    end
  endgenerate

  // R3: two copies that agree decide the local vote
  assert_vote_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[0] == raw[1]) |-> (vote == raw[0]));
  assert_vote_bc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[1] == raw[2]) |-> (vote == raw[1]));
endmodule

// File: rtl/tac_report_slot.sv
module tac_report_slot
  import tac_pkg::*;
#(
  parameter int unsigned PW    = 40,
  parameter int unsigned RPT_W = 16,
  parameter int unsigned TS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             err,
  input  logic [RPT_W-1:0] rpt_cfg,
  input  logic [PW-1:0]    payload,
  input  logic             rec_ready,
  output logic             rec_valid,
  output logic [PW-1:0]    rec_payload,
  output kind_t            rec_kind,
  output logic [TS_W-1:0]  rec_ts
);
  logic [RPT_W-1:0] rpt_q, rpt_d;
  logic [TS_W-1:0]  ts_q, ts_d;
  logic             vld_q, vld_d;
  logic [PW-1:0]    pl_q, pl_d;
  kind_t            kind_q, kind_d;
  logic [TS_W-1:0]  rts_q, rts_d;
  logic             due, fire, take;

  always_comb begin
    due  = (rpt_cfg != '0) && (rpt_q >= rpt_cfg - RPT_W'(1));
    fire = tick && (err || due);
    take = !vld_q || rec_ready;
    rpt_d = rpt_q;
    ts_d  = ts_q;
    if (tick) begin
      rpt_d = (due || rpt_cfg == '0) ? '0 : rpt_q + RPT_W'(1);
      ts_d  = ts_q + TS_W'(1);
    end
    vld_d  = vld_q;
    pl_d   = pl_q;
    kind_d = kind_q;
    rts_d  = rts_q;
    if (fire && take) begin
      vld_d         = 1'b1;
      pl_d          = payload;
      kind_d        = '0;
      kind_d[K_ERR] = err;
      kind_d[K_PER] = due;
      rts_d         = ts_q;
    end else if (rec_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_q  <= '0;
      ts_q   <= '0;
      vld_q  <= 1'b0;
      pl_q   <= '0;
      kind_q <= '0;
      rts_q  <= '0;
    end else begin
      rpt_q  <= rpt_d;
      ts_q   <= ts_d;
      vld_q  <= vld_d;
      pl_q   <= pl_d;
      kind_q <= kind_d;
      rts_q  <= rts_d;
    end
  end

  assign rec_valid   = vld_q;
  assign rec_payload = pl_q;
  assign rec_kind    = kind_q;
  assign rec_ts      = rts_q;

  // R9: a stalled record keeps every field
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_payload) &&
                                   $stable(rec_kind) && $stable(rec_ts)));
  // R8: the tick count steps by one per tick and rests otherwise
  assert_ts_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (ts_q == TS_W'($past(ts_q) + TS_W'(1))));
  assert_ts_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ts_q));
  // R5/R6: an offered record names at least one cause
  assert_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_kind != '0));
endmodule

// File: rtl/tmr_adder_checker.sv
module tmr_adder_checker
  import tac_pkg::*;
#(
  parameter int unsigned OPW    = 4,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned INTV_W = 16,
  parameter int unsigned RPT_W  = 16,
  parameter int unsigned TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic [INTV_W-1:0] step_cfg,
  input  logic [RPT_W-1:0]  rpt_cfg,
  output logic              eff_tick,
  output logic [OPW-1:0]    op_a,
  output logic [OPW-1:0]    op_b,
  input  logic [OPW:0]      sum_a,
  input  logic [OPW:0]      sum_b,
  input  logic [OPW:0]      sum_c,
  input  logic [OPW:0]      sum_voted,
  input  logic              rec_ready,
  output logic              rec_valid,
  output logic [OPW-1:0]    rec_op_a,
  output logic [OPW:0]      rec_raw_a,
  output logic [OPW:0]      rec_raw_b,
  output logic [OPW:0]      rec_raw_c,
  output logic [OPW:0]      rec_ext,
  output logic [OPW:0]      rec_loc,
  output logic [OPW:0]      rec_exp,
  output logic [4:0]        rec_mask,
  output logic [1:0]        rec_kind,
  output logic [TS_W-1:0]   rec_ts
);
  localparam int unsigned SUMW = OPW + 1;
  localparam int unsigned PW   = OPW + 6 * SUMW + NRES;

  logic                      tick;
  logic [NRAW-1:0][SUMW-1:0] raw;
  logic [SUMW-1:0]           expect_sum, vote;
  mask_t                     mask;
  logic [PW-1:0]             payload, rec_payload;
  kind_t                     kind;

  tac_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .tick(tick)
  );

  tac_stim_gen #(.OPW(OPW), .INTV_W(INTV_W)) u_stim (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step_cfg(step_cfg),
    .op_a(op_a), .op_b(op_b)
  );

  assign raw[0] = sum_a;
  assign raw[1] = sum_b;
  assign raw[2] = sum_c;

  tac_result_check #(.OPW(OPW), .SUMW(SUMW)) u_check (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .raw(raw),
    .ext(sum_voted), .expect_sum(expect_sum), .vote(vote), .mask(mask)
  );

  assign payload = {op_a, sum_a, sum_b, sum_c, sum_voted, vote, expect_sum, mask};

  tac_report_slot #(.PW(PW), .RPT_W(RPT_W), .TS_W(TS_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .tick(tick), .err(|mask), .rpt_cfg(rpt_cfg),
    .payload(payload), .rec_ready(rec_ready), .rec_valid(rec_valid),
    .rec_payload(rec_payload), .rec_kind(kind), .rec_ts(rec_ts)
  );

  assign {rec_op_a, rec_raw_a, rec_raw_b, rec_raw_c, rec_ext, rec_loc,
          rec_exp, rec_mask} = rec_payload;
  assign rec_kind = kind;
  assign eff_tick = tick;

  // R5: the error kind bit agrees with the captured mask
  assert_err_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_kind[K_ERR] == (rec_mask != '0)));
endmodule

// File: tb/test_tmr_adder_checker.sv
module test_tmr_adder_checker;
  typedef struct packed {
    logic [3:0]  a;
    logic [4:0]  r0, r1, r2, ev, lv, ex;
    logic [4:0]  mask;
    logic [1:0]  kind;
    logic [15:0] ts;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_cfg = '0, step_cfg = 16'd1, rpt_cfg = '0;
  logic        eff_tick, rec_ready = 1'b1, rec_valid;
  logic [3:0]  op_a, op_b, rec_op_a;
  logic [4:0]  sum_a, sum_b, sum_c, sum_voted;
  logic [4:0]  rec_raw_a, rec_raw_b, rec_raw_c, rec_ext, rec_loc, rec_exp, rec_mask;
  logic [1:0]  rec_kind;
  logic [15:0] rec_ts;
  logic [4:0]  f0 = '0, f1 = '0, f2 = '0, fv = '0;

  int    n_cmp = 0, n_bad = 0, n_both = 0;
  bit    done = 1'b0;
  string cur_req = "R10";
  rec_t  q[$];

  always #5 clk = ~clk;

  // adders under test, with fault injection
  assign sum_a     = ({1'b0, op_a} + {1'b0, op_b}) ^ f0;
  assign sum_b     = ({1'b0, op_a} + {1'b0, op_b}) ^ f1;
  assign sum_c     = ({1'b0, op_a} + {1'b0, op_b}) ^ f2;
  assign sum_voted = ({1'b0, op_a} + {1'b0, op_b}) ^ fv;

  tmr_adder_checker i_tmr_adder_checker (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .step_cfg(step_cfg),
    .rpt_cfg(rpt_cfg), .eff_tick(eff_tick), .op_a(op_a), .op_b(op_b),
    .sum_a(sum_a), .sum_b(sum_b), .sum_c(sum_c), .sum_voted(sum_voted),
    .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_op_a(rec_op_a),
    .rec_raw_a(rec_raw_a), .rec_raw_b(rec_raw_b), .rec_raw_c(rec_raw_c),
    .rec_ext(rec_ext), .rec_loc(rec_loc), .rec_exp(rec_exp),
    .rec_mask(rec_mask), .rec_kind(rec_kind), .rec_ts(rec_ts)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model (driver side): predicts every record from the requirements
  logic [15:0] m_div, m_step, m_rpt, m_ts;
  logic [3:0]  m_a;
  bit          m_full;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = '0; m_step = '0; m_rpt = '0; m_ts = '0; m_a = '0; m_full = 0;
    end else begin
      bit mtick, due, fire;
      rec_t e;
      mtick = (div_cfg <= 1) || (m_div >= div_cfg - 16'd1);
      if (mtick) begin
        m_div  = '0;
        e.a    = m_a;
        e.ex   = {1'b0, m_a} + 5'd1;
        e.r0   = e.ex ^ f0; e.r1 = e.ex ^ f1; e.r2 = e.ex ^ f2; e.ev = e.ex ^ fv;
        e.lv   = (e.r0 & e.r1) | (e.r0 & e.r2) | (e.r1 & e.r2);
        e.mask = {e.lv != e.ex, e.ev != e.ex, e.r2 != e.ex, e.r1 != e.ex, e.r0 != e.ex};
        due    = (rpt_cfg != 0) && (m_rpt >= rpt_cfg - 16'd1);
        m_rpt  = (due || rpt_cfg == 0) ? 16'd0 : m_rpt + 16'd1;
        e.kind = {due, e.mask != 0};
        e.ts   = m_ts;
        fire   = (e.mask != 0) || due;
        if (fire && (!m_full || rec_ready)) begin q.push_back(e); m_full = 1; end
        else if (rec_ready) m_full = 0;
        if (step_cfg <= 1 || m_step >= step_cfg - 16'd1) begin m_a = m_a + 4'd1; m_step = '0; end
        else m_step = m_step + 16'd1;
        m_ts = m_ts + 16'd1;
      end else begin
        m_div = m_div + 16'd1;
        if (rec_ready) m_full = 0;
      end
    end
  end

  // monitor: operand ports and record transfers, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2", "op_a", 64'(op_a), 64'(m_a));
      check("R2", "op_b", 64'(op_b), 64'd1);
      if (rec_valid && rec_ready) begin
        rec_t act;
        act = '{rec_op_a, rec_raw_a, rec_raw_b, rec_raw_c, rec_ext, rec_loc,
                rec_exp, rec_mask, rec_kind, rec_ts};
        if (act.kind == 2'b11) n_both++;
        if (q.size() == 0) check(cur_req, "unexpected record", 64'(act), 64'd0);
        else check(cur_req, "record (R7 fields)", 64'(act), 64'(q.pop_front()));
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    rec_t held;
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", "op_a in reset", 64'(op_a), 64'd0);
    check("R10", "rec_valid in reset", 64'(rec_valid), 64'd0);
    rst_n = 1'b1;
    run(1);
    check("R10", "rec_valid after reset", 64'(rec_valid), 64'd0);

    // R1/R2: full rate, clean adders, operand wraps past 15
    cur_req = "R2";
    cnt = 0;
    for (int i = 0; i < 8; i++) begin if (eff_tick) cnt++; @(negedge clk); end
    check("R1", "ticks at full rate", 64'(cnt), 64'd8);
    run(30);

    // R3/R4: faults on raw copies and the external vote
    cur_req = "R3";
    f0 = 5'b00100; run(4);
    f0 = 5'b00001; f1 = 5'b00001; run(4);  // two copies wrong: local vote wrong too
    f0 = '0; f1 = '0; fv = 5'b10000; run(3);
    fv = '0; f2 = 5'b11111; run(2);
    f2 = '0; run(3);

    // R4: operand held, upset still caught on every tick
    cur_req = "R4";
    step_cfg = 16'd50;
    run(5);
    f1 = 5'b00100; run(3);
    f1 = '0; run(5);

    // R1: divided tick
    div_cfg = 16'd4; step_cfg = 16'd2;
    run(3);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin if (eff_tick) cnt++; @(negedge clk); end
    check("R1", "ticks with divider 4", 64'(cnt), 64'd5);

    // R6/R8: periodic reports only
    cur_req = "R6";
    div_cfg = 16'd3; rpt_cfg = 16'd4;
    run(60);

    // R5 with R6 on one tick: error and period coincide
    cur_req = "R5";
    div_cfg = 16'd1; rpt_cfg = 16'd3; step_cfg = 16'd1;
    f0 = 5'b01000; run(7);
    f0 = '0; run(2);
    check("R6", "records with both kind bits", 64'(n_both >= 2), 64'd1);

    // R9: stalled record is held, later reports dropped
    cur_req = "R9";
    rpt_cfg = '0; div_cfg = '0;
    run(2);
    rec_ready = 1'b0; f1 = 5'b00010;
    cnt = 0;
    while (!rec_valid && cnt < 20) begin @(negedge clk); cnt++; end
    check("R9", "stalled record offered", 64'(rec_valid), 64'd1);
    held = '{rec_op_a, rec_raw_a, rec_raw_b, rec_raw_c, rec_ext, rec_loc,
             rec_exp, rec_mask, rec_kind, rec_ts};
    run(5);
    check("R9", "valid still high", 64'(rec_valid), 64'd1);
    check("R9", "record unchanged", 64'({rec_op_a, rec_raw_a, rec_raw_b, rec_raw_c,
          rec_ext, rec_loc, rec_exp, rec_mask, rec_kind, rec_ts}), 64'(held));
    f1 = '0;
    run(1);
    rec_ready = 1'b1;
    run(10);

    check("R9", "predicted records left over", 64'(q.size()), 64'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule